// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Per-Port Output Latency

This block is a true dual-port synchronous memory of 18-bit words. Its two ports, A and B, are fully independent. Each has its own clock and reset, two chip enables, a read/write strobe, an asynchronous output enable, and two byte-lane enables. Each port registers its address, write data, lane enables and control inputs on the rising edge of its own clock. Either port may read or write any word, and both ports may reach the same word in the same cycle.

Each port has a static mode strap. In flow-through mode, read data appears in the cycle after the edge that captured the address. In pipelined mode, one more register stage follows, so both data and output qualification arrive one edge later. The chip-enable and lane-enable decisions travel with the data, which means a deselect reaches a pipelined port's outputs two edges after it is presented. A per-port sleep input makes that port ignore all of its dynamic inputs. The mode strap and the sleep input itself stay effective during sleep.

The depth is a parameter so that simulation models stay small. Read data is qualified by a drive flag, and the data bus reads as zero whenever the flag is low.

Top module: `dpram_dual_lat`

## Requirements
- R1: A word is 18 bits. Lane enable bit 1 covers data bits 17..9 and bit 0 covers bits 8..0. A write changes only the lanes whose enable is 1. On a read, a lane whose enable was 0 at capture returns zero.
- R2: A port is selected only when `ce0_n` is 0 and `ce1` is 1. An unselected access writes nothing, and the port's read output stays disabled.
- R3: All dynamic inputs are captured on the rising clock edge. A write captured at edge k is visible to a read captured at edge k+1 or later, on either port.
- R4: With `pipe` = 0 (flow-through), a read captured at edge k drives `rdrive` = 1 and the data from just after edge k until edge k+1.
- R5: With `pipe` = 1 (pipelined), a read captured at edge k is presented from just after edge k+1. A deselect or a write captured at edge k disables the output only after edge k+1.
- R6: Both ports may access the same word in the same cycle. A read captured at the same edge as the other port's write to that word returns the previous contents. Two writes to one word in one cycle are undefined.
- R7: While `sleep` is 1 at an edge, that edge captures no access: nothing is written and the port's read output is disabled as if deselected.
- R8: `oe_n` is active-low and asynchronous. `rdrive` = 1 only when a read is being presented and `oe_n` is 0, and `rdata` is zero whenever `rdrive` is 0.
- R9: While a port's reset is low, its output is disabled and its storage bank is cleared. After both resets, every word reads zero.
- R10: Each port's `pipe` strap is independent, so one port may run flow-through while the other runs pipelined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A asynchronous reset, active low |
| a_pipe | input | 1 | Port A mode strap: 0 flow-through, 1 pipelined |
| a_sleep | input | 1 | Port A sleep: ignore dynamic inputs |
| a_ce0_n | input | 1 | Port A chip enable, active low |
| a_ce1 | input | 1 | Port A chip enable, active high |
| a_we | input | 1 | Port A access type: 1 write, 0 read |
| a_oe_n | input | 1 | Port A output enable, active low, asynchronous |
| a_be | input | 2 | Port A lane enables, bit 1 upper lane |
| a_addr | input | AW | Port A word address |
| a_wdata | input | 18 | Port A write data |
| a_rdata | output | 18 | Port A read data, zero when not driven |
| a_rdrive | output | 1 | Port A read data qualifier |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B asynchronous reset, active low |
| b_pipe | input | 1 | Port B mode strap: 0 flow-through, 1 pipelined |
| b_sleep | input | 1 | Port B sleep: ignore dynamic inputs |
| b_ce0_n | input | 1 | Port B chip enable, active low |
| b_ce1 | input | 1 | Port B chip enable, active high |
| b_we | input | 1 | Port B access type: 1 write, 0 read |
| b_oe_n | input | 1 | Port B output enable, active low, asynchronous |
| b_be | input | 2 | Port B lane enables, bit 1 upper lane |
| b_addr | input | AW | Port B word address |
| b_wdata | input | 18 | Port B write data |
| b_rdata | output | 18 | Port B read data, zero when not driven |
| b_rdrive | output | 1 | Port B read data qualifier |

## Verification
The bench builds the block with its default depth of 64 words, so the 6-bit address reaches both the first and the last word. Random addresses are drawn mostly from a 16-word window, which makes same-word accesses by the two ports frequent. The bench runs one phase with port A flow-through and port B pipelined, then swaps the straps. This puts both latencies, and the two-edge deselect, against the same reference memory within each phase.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int unsigned LANES     = 2;
  localparam int unsigned LANE_BITS = 9;
  localparam int unsigned WORD_BITS = LANES * LANE_BITS;

  // Expand per-lane enables into a per-bit mask.
  function automatic logic [WORD_BITS-1:0] lane_mask(input logic [LANES-1:0] be);
    logic [WORD_BITS-1:0] m;
    for (int l = 0; l < LANES; l++) begin
      m[l*LANE_BITS +: LANE_BITS] = {LANE_BITS{be[l]}};
    end
    return m;
  endfunction

  // Replace only masked bits of a stored word.
  function automatic logic [WORD_BITS-1:0] lane_merge(input logic [WORD_BITS-1:0] old_w,
                                                      input logic [WORD_BITS-1:0] new_w,
                                                      input logic [WORD_BITS-1:0] m);
    return (old_w & ~m) | (new_w & m);
  endfunction
endpackage

// File: rtl/dpr_store.sv
module dpr_store import dpr_pkg::*; #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                 a_clk,
  input  logic                 a_rst_n,
  input  logic                 a_wr,
  input  logic [AW-1:0]        a_addr,
  input  logic [WORD_BITS-1:0] a_mask,
  input  logic [WORD_BITS-1:0] a_wdata,
  output logic [WORD_BITS-1:0] a_rword,
  input  logic                 b_clk,
  input  logic                 b_rst_n,
  input  logic                 b_wr,
  input  logic [AW-1:0]        b_addr,
  input  logic [WORD_BITS-1:0] b_mask,
  input  logic [WORD_BITS-1:0] b_wdata,
  output logic [WORD_BITS-1:0] b_rword
);
  // Each port owns one bank; the stored word is the XOR of both banks.
  logic [WORD_BITS-1:0] bank_a [DEPTH];
  logic [WORD_BITS-1:0] bank_b [DEPTH];

  always_ff @(posedge a_clk or negedge a_rst_n) begin
    if (!a_rst_n) begin
      for (int i = 0; i < DEPTH; i++) bank_a[i] <= '0;
    end else if (a_wr) begin
      bank_a[a_addr] <= lane_merge(bank_a[a_addr], a_wdata ^ bank_b[a_addr], a_mask);
    end
  end

  always_ff @(posedge b_clk or negedge b_rst_n) begin
    if (!b_rst_n) begin
      for (int i = 0; i < DEPTH; i++) bank_b[i] <= '0;
    end else if (b_wr) begin
      bank_b[b_addr] <= lane_merge(bank_b[b_addr], b_wdata ^ bank_a[b_addr], b_mask);
    end
  end

  assign a_rword = bank_a[a_addr] ^ bank_b[a_addr];
  assign b_rword = bank_a[b_addr] ^ bank_b[b_addr];
endmodule

// File: rtl/dpr_port.sv
module dpr_port import dpr_pkg::*; #(
  parameter int unsigned AW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pipe,
  input  logic                 sleep,
  input  logic                 ce0_n,
  input  logic                 ce1,
  input  logic                 we,
  input  logic                 oe_n,
  input  logic [LANES-1:0]     be,
  input  logic [AW-1:0]        addr,
  input  logic [WORD_BITS-1:0] wdata,
  input  logic [WORD_BITS-1:0] mem_rword,
  output logic                 mem_wr,
  output logic [AW-1:0]        mem_addr,
  output logic [WORD_BITS-1:0] mem_mask,
  output logic [WORD_BITS-1:0] mem_wdata,
  output logic [WORD_BITS-1:0] rdata,
  output logic                 rdrive
);
  // Named events for the checks below.
  logic sel_in, cap_rd, cap_wr;
  assign sel_in = !ce0_n && ce1 && !sleep;
  assign cap_rd = sel_in && !we;
  assign cap_wr = sel_in && we;

  // Input register stage.
  logic                 s1_rd, s1_wr;
  logic [AW-1:0]        s1_addr;
  logic [WORD_BITS-1:0] s1_mask, s1_data;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_rd <= 1'b0; s1_wr <= 1'b0;
      s1_addr <= '0; s1_mask <= '0; s1_data <= '0;
    end else begin
      s1_rd <= cap_rd;
      s1_wr <= cap_wr;
      if (!sleep) begin
        s1_addr <= addr;
        s1_mask <= lane_mask(be);
        s1_data <= wdata;
      end
    end
  end

  assign mem_wr    = s1_wr;
  assign mem_addr  = s1_addr;
  assign mem_mask  = s1_mask;
  assign mem_wdata = s1_data;

  // Output register stage, used in pipelined mode; select and lanes ride along.
  logic                 s2_rd;
  logic [WORD_BITS-1:0] s2_mask, s2_word;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_rd <= 1'b0; s2_mask <= '0; s2_word <= '0;
    end else begin
      s2_rd   <= s1_rd;
      s2_mask <= s1_mask;
      s2_word <= mem_rword;
    end
  end

  logic                 out_en;
  logic [WORD_BITS-1:0] out_word, out_mask;
  assign out_en   = pipe ? s2_rd   : s1_rd;
  assign out_word = pipe ? s2_word : mem_rword;
  assign out_mask = pipe ? s2_mask : s1_mask;

  assign rdrive = out_en && !oe_n;
  assign rdata  = rdrive ? (out_word & out_mask) : '0;

  // Cycles since reset, saturating, so latency checks never look before reset.
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  AST_WR_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(!ce0_n && ce1 && we)); // R2
  AST_SLEEP_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!mem_wr && !s1_rd)); // R7
  AST_FLOW_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && !pipe && $past(!pipe)) |-> (out_en == $past(cap_rd))); // R4
  AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && pipe && $past(pipe) && $past(pipe, 2)) |-> (out_en == $past(cap_rd, 2))); // R5
endmodule

// File: rtl/dpram_dual_lat.sv
module dpram_dual_lat import dpr_pkg::*; #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned DW   = WORD_BITS
) (
  input  logic          a_clk,
  input  logic          a_rst_n,
  input  logic          a_pipe,
  input  logic          a_sleep,
  input  logic          a_ce0_n,
  input  logic          a_ce1,
  input  logic          a_we,
  input  logic          a_oe_n,
  input  logic [1:0]    a_be,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_rdrive,
  input  logic          b_clk,
  input  logic          b_rst_n,
  input  logic          b_pipe,
  input  logic          b_sleep,
  input  logic          b_ce0_n,
  input  logic          b_ce1,
  input  logic          b_we,
  input  logic          b_oe_n,
  input  logic [1:0]    b_be,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_rdrive
);
  logic          a_wr, b_wr;
  logic [AW-1:0] a_maddr, b_maddr;
  logic [DW-1:0] a_mask, b_mask, a_mwd, b_mwd, a_rword, b_rword;

  dpr_port #(.AW(AW)) port_a_i (
    .clk(a_clk), .rst_n(a_rst_n), .pipe(a_pipe), .sleep(a_sleep),
    .ce0_n(a_ce0_n), .ce1(a_ce1), .we(a_we), .oe_n(a_oe_n), .be(a_be),
    .addr(a_addr), .wdata(a_wdata), .mem_rword(a_rword),
    .mem_wr(a_wr), .mem_addr(a_maddr), .mem_mask(a_mask), .mem_wdata(a_mwd),
    .rdata(a_rdata), .rdrive(a_rdrive));

  dpr_port #(.AW(AW)) port_b_i (
    .clk(b_clk), .rst_n(b_rst_n), .pipe(b_pipe), .sleep(b_sleep),
    .ce0_n(b_ce0_n), .ce1(b_ce1), .we(b_we), .oe_n(b_oe_n), .be(b_be),
    .addr(b_addr), .wdata(b_wdata), .mem_rword(b_rword),
    .mem_wr(b_wr), .mem_addr(b_maddr), .mem_mask(b_mask), .mem_wdata(b_mwd),
    .rdata(b_rdata), .rdrive(b_rdrive));

  dpr_store #(.DEPTH(DEPTH), .AW(AW)) store_i (
    .a_clk(a_clk), .a_rst_n(a_rst_n), .a_wr(a_wr), .a_addr(a_maddr),
    .a_mask(a_mask), .a_wdata(a_mwd), .a_rword(a_rword),
    .b_clk(b_clk), .b_rst_n(b_rst_n), .b_wr(b_wr), .b_addr(b_maddr),
    .b_mask(b_mask), .b_wdata(b_mwd), .b_rword(b_rword));
endmodule

// File: tb/dpram_dual_lat_tb_top.sv
module dpram_dual_lat_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          pipe [2], sleep [2], ce0_n [2], ce1 [2], we [2], oe_n [2];
  logic [1:0]    be   [2];
  logic [AW-1:0] addr [2];
  logic [17:0]   wdata[2];
  logic [17:0]   rdata[2];
  logic          rdrive[2];

  dpram_dual_lat #(.DEPTH(DEPTH)) dut_i (
    .a_clk(clk), .a_rst_n(rst_n), .a_pipe(pipe[0]), .a_sleep(sleep[0]),
    .a_ce0_n(ce0_n[0]), .a_ce1(ce1[0]), .a_we(we[0]), .a_oe_n(oe_n[0]),
    .a_be(be[0]), .a_addr(addr[0]), .a_wdata(wdata[0]),
    .a_rdata(rdata[0]), .a_rdrive(rdrive[0]),
    .b_clk(clk), .b_rst_n(rst_n), .b_pipe(pipe[1]), .b_sleep(sleep[1]),
    .b_ce0_n(ce0_n[1]), .b_ce1(ce1[1]), .b_we(we[1]), .b_oe_n(oe_n[1]),
    .b_be(be[1]), .b_addr(addr[1]), .b_wdata(wdata[1]),
    .b_rdata(rdata[1]), .b_rdrive(rdrive[1]));

  int          n_vec = 0;
  int          n_bad = 0;
  logic [17:0] model [DEPTH];
  logic        exp_en_prev [2];
  logic [17:0] exp_d_prev  [2];
  string       tag = "R9";

  // Lane k covers bits 9k+8..9k.
  function automatic logic [17:0] bits_of(input logic [1:0] e);
    return {e[1] ? 9'h1FF : 9'h000, e[0] ? 9'h1FF : 9'h000};
  endfunction

  function automatic logic picked(input int p);
    return (ce0_n[p] == 1'b0) && (ce1[p] == 1'b1) && !sleep[p];
  endfunction

  task automatic chk(input int p, input logic g_en, input logic [17:0] g_d,
                     input logic e_en, input logic [17:0] e_d);
    n_vec++;
    if (g_en !== e_en || g_d !== e_d) begin
      n_bad++;
      $display("FAIL %s port%0d: got drive=%0b data=%h expected drive=%0b data=%h",
               tag, p, g_en, g_d, e_en, e_d);
    end
  endtask

  task automatic idle(input int p);
    sleep[p] = 1'b0; ce0_n[p] = 1'b1; ce1[p] = 1'b1; we[p] = 1'b0;
    oe_n[p] = 1'b0; be[p] = 2'b11; addr[p] = '0; wdata[p] = '0;
  endtask

  task automatic acc(input int p, input logic w, input logic [1:0] e,
                     input int a, input logic [17:0] d);
    sleep[p] = 1'b0; ce0_n[p] = 1'b0; ce1[p] = 1'b1; we[p] = w;
    oe_n[p] = 1'b0; be[p] = e; addr[p] = AW'(a); wdata[p] = d;
  endtask

  // One clock: predict, update reference, clock, then compare off the edge.
  task automatic step();
    logic        e_en [2];
    logic [17:0] e_d  [2];
    for (int p = 0; p < 2; p++) begin
      e_en[p] = picked(p) && !we[p];
      e_d[p]  = model[addr[p]] & bits_of(be[p]);
    end
    for (int p = 0; p < 2; p++)
      if (picked(p) && we[p])
        model[addr[p]] = (model[addr[p]] & ~bits_of(be[p])) | (wdata[p] & bits_of(be[p]));
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      logic        ee = pipe[p] ? exp_en_prev[p] : e_en[p];
      logic [17:0] ed = pipe[p] ? exp_d_prev[p]  : e_d[p];
      ee = ee && !oe_n[p];
      chk(p, rdrive[p], rdata[p], ee, ee ? ed : 18'h0);
      exp_en_prev[p] = e_en[p];
      exp_d_prev[p]  = e_d[p];
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL R9 watchdog: got running expected finished");
    summary();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    for (int p = 0; p < 2; p++) begin
      idle(p); pipe[p] = 1'b0; exp_en_prev[p] = 1'b0; exp_d_prev[p] = '0;
    end
    repeat (3) @(negedge clk);
    // R9: output disabled during reset
    chk(0, rdrive[0], rdata[0], 1'b0, 18'h0);
    chk(1, rdrive[1], rdata[1], 1'b0, 18'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: storage cleared, last word reads zero
    acc(0, 1'b0, 2'b11, DEPTH-1, '0); acc(1, 1'b0, 2'b11, 0, '0); step();

    tag = "R4";
    acc(0, 1'b1, 2'b11, 5, 18'h2A5A5); idle(1); step();
    acc(0, 1'b0, 2'b11, 5, '0); step();     // R3: visible next edge
    idle(0); step();

    tag = "R1";
    acc(0, 1'b1, 2'b10, 5, 18'h3FFFF); step();
    acc(0, 1'b0, 2'b11, 5, '0); step();
    acc(0, 1'b0, 2'b01, 5, '0); step();
    acc(0, 1'b1, 2'b01, DEPTH-1, 18'h155AA); step();
    acc(0, 1'b0, 2'b11, DEPTH-1, '0); step();

    tag = "R6";
    acc(0, 1'b1, 2'b11, 7, 18'h1C3C3); acc(1, 1'b0, 2'b11, 7, '0); step();
    acc(0, 1'b0, 2'b11, 7, '0);        acc(1, 1'b0, 2'b11, 7, '0); step();

    tag = "R2";
    acc(0, 1'b1, 2'b11, 9, 18'h0F0F0); ce0_n[0] = 1'b1; idle(1); step();
    acc(0, 1'b1, 2'b11, 9, 18'h0F0F0); ce1[0] = 1'b0; step();
    acc(0, 1'b0, 2'b11, 9, '0); ce0_n[0] = 1'b1; step();
    acc(0, 1'b0, 2'b11, 9, '0); step();

    tag = "R7";
    acc(1, 1'b1, 2'b11, 9, 18'h12345); sleep[1] = 1'b1; idle(0); step();
    acc(1, 1'b0, 2'b11, 9, '0); sleep[1] = 1'b1; step();
    acc(1, 1'b0, 2'b11, 9, '0); step();

    tag = "R8";
    acc(1, 1'b0, 2'b11, 7, '0); oe_n[1] = 1'b1; step();
    acc(1, 1'b0, 2'b11, 7, '0); step();
    idle(1); step();

    tag = "R5";
    pipe[1] = 1'b1; idle(0); step(); step();
    acc(1, 1'b0, 2'b11, 5, '0); step();
    idle(1); step();                          // still presenting the prior read
    acc(1, 1'b0, 2'b11, 7, '0); step();
    acc(1, 1'b1, 2'b11, 8, 18'h00777); step(); // write after read: read shown
    idle(1); step();

    for (int phase = 0; phase < 2; phase++) begin
      tag = (phase == 0) ? "R10" : "R3";
      pipe[0] = phase[0]; pipe[1] = !phase[0];
      idle(0); idle(1); step(); step();
      for (int n = 0; n < 600; n++) begin
        for (int p = 0; p < 2; p++) begin
          int a = ($urandom % 20 == 0) ? DEPTH-1 : int'($urandom % 16);
          acc(p, 1'($urandom), 2'($urandom), a, 18'($urandom));
          if ($urandom % 8 == 0) sleep[p] = 1'b1;
          if ($urandom % 10 == 0) ce0_n[p] = 1'b1;
          if ($urandom % 10 == 0) ce1[p] = 1'b0;
          if ($urandom % 8 == 0) oe_n[p] = 1'b1;
        end
        if (picked(0) && picked(1) && we[0] && we[1] && addr[0] == addr[1])
          addr[1] = addr[1] ^ AW'(1);
        step();
      end
    end
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_0140));
  end
endmodule